// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block is the frame timing engine of a full-speed USB host controller. Software programs a 14-bit frame interval, a 15-bit largest-packet budget and an interval toggle through a single write port. While the controller sits in its operational state, every pulse of the 12 MHz bit-time enable lowers a remaining-time count by one. When the count is already zero, the next bit time closes the frame. At that point the count reloads from the interval field, the remaining-time toggle takes the value of the interval toggle, and the 16-bit frame number advances.

Every frame boundary produces a one-cycle start-of-frame strobe. It also produces interrupt-set requests laid out at the bit positions of the controller's interrupt status word, so the surrounding controller can OR them straight into that word. Entering the operational state reloads the count without a strobe, so the first start of frame arrives one whole frame later. In every other functional state the count is frozen, and the remaining-time read port shows only the toggle.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the interval register reads 0x2778_2EDF (toggle 0, packet budget 0x2778, interval 11999), the frame number is 0, the strobe and all interrupt-set bits are low, and the remaining-time read is 0 in the reset state.
- R2: A write places data bits 13:0 in the interval, bits 30:16 in the packet budget and bit 31 in the interval toggle; bits 15:14 read back as 0.
- R3: While the functional state is not operational, the remaining-time read is the toggle in bit 31 with bits 30:0 zero, and bit-time pulses change neither the count nor the frame number.
- R4: On entry to the operational state the count loads the interval with no strobe, so the first strobe comes on the (interval+1)-th bit-time pulse after entry.
- R5: While operational, the remaining-time read is {toggle, 17'b0, count}; each bit-time pulse lowers a nonzero count by one, and a cycle without a pulse holds it.
- R6: A bit-time pulse with the count at zero is a frame boundary: the count reloads from the interval, the toggle loads from the interval toggle, and the strobe is high for exactly the following cycle.
- R7: The interrupt-set output has bit 2 (start of frame) high in exactly the cycles the strobe is high.
- R8: The frame number increases by one at every boundary and wraps from 0xFFFF to 0.
- R9: Interrupt-set bit 5 (frame-number overflow) pulses together with the strobe in exactly those boundaries where frame-number bit 15 changes, in both directions.
- R10: The functional-state input encodes reset=00, resume=01, operational=10, suspend=11; only 10 lets the count run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, restores defaults |
| bit_tick | input | 1 | One-cycle pulse per 12 MHz bit time |
| func_state | input | 2 | Controller functional state |
| cfg_wr | input | 1 | Write strobe for the interval register |
| cfg_wdata | input | 32 | Write data for the interval register |
| cfg_interval | output | 32 | Interval register read value |
| frame_remaining | output | 32 | Remaining-time read value |
| frame_number | output | 16 | Current frame number |
| sof_pulse | output | 1 | Start-of-frame strobe |
| int_set | output | 8 | Interrupt-set requests (bit 2 start of frame, bit 5 frame-number overflow) |

## Verification
The overflow interrupt is the hardest case to reach, because bit 15 of the frame number changes only once every 32768 frames. The stimulus programs an interval of zero, so each bit-time pulse closes a frame. It then holds the bit-time enable high for a little over 65536 cycles. Both the 0→1 flip and the 1→0 wrap of bit 15 are crossed, and the overflow bit is compared against the bench's own copy of bit 15 on every boundary.

// File: rtl/usb_frame_timer_pkg.sv
package usb_frame_timer_pkg;
    localparam int REG_W   = 32;
    localparam int CNT_W   = 14;
    localparam int SIZE_W  = 15;
    localparam int SIZE_LSB = 16;
    localparam int FN_W    = 16;
    localparam int INT_W   = 8;
    localparam int INT_SOF = 2;
    localparam int INT_FNO = 5;

    typedef enum logic [1:0] {
        FS_RESET   = 2'b00,
        FS_RESUME  = 2'b01,
        FS_OPER    = 2'b10,
        FS_SUSPEND = 2'b11
    } fstate_e;
endpackage

// File: rtl/uft_interval_reg.sv
module uft_interval_reg
    import usb_frame_timer_pkg::*;
#(
    parameter logic [CNT_W-1:0]  DEF_INTERVAL = 14'd11999,
    parameter logic [SIZE_W-1:0] DEF_SIZE     = 15'h2778
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  interval,
    output logic              ivl_toggle,
    output logic [REG_W-1:0]  reg_val
);
    localparam int GAP_W = SIZE_LSB - CNT_W;

    typedef struct packed {
        logic              tog;
        logic [SIZE_W-1:0] size;
        logic [CNT_W-1:0]  ivl;
    } ivl_reg_t;

    ivl_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.ivl  = wr_data[CNT_W-1:0];
            r_d.size = wr_data[SIZE_LSB +: SIZE_W];
            r_d.tog  = wr_data[REG_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ivl  <= DEF_INTERVAL;
            r_q.size <= DEF_SIZE;
            r_q.tog  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign interval   = r_q.ivl;
    assign ivl_toggle = r_q.tog;
    assign reg_val    = {r_q.tog, r_q.size, {GAP_W{1'b0}}, r_q.ivl};

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (interval == $past(wr_data[CNT_W-1:0])) && (ivl_toggle == $past(wr_data[REG_W-1])));
endmodule

// File: rtl/uft_countdown.sv
module uft_countdown
    import usb_frame_timer_pkg::*;
#(
    parameter logic [CNT_W-1:0] DEF_INTERVAL = 14'd11999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oper,
    input  logic             bit_tick,
    input  logic [CNT_W-1:0] interval,
    input  logic             ivl_toggle,
    output logic [CNT_W-1:0] count,
    output logic             rem_toggle,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tog;
        logic             was_oper;
    } cd_state_t;

    cd_state_t s_d, s_q;
    logic      wrap_d;

    always_comb begin
        s_d          = s_q;
        wrap_d       = 1'b0;
        s_d.was_oper = oper;
        if (oper && !s_q.was_oper) begin
            s_d.cnt = interval;
        end else if (oper && bit_tick) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = interval;
                s_d.tog = ivl_toggle;
                wrap_d  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt      <= DEF_INTERVAL;
            s_q.tog      <= 1'b0;
            s_q.was_oper <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count      = s_q.cnt;
    assign rem_toggle = s_q.tog;
    assign wrap       = wrap_d;

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (oper && s_q.was_oper && bit_tick && count != '0) |=> count == $past(count) - 1'b1);

    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !oper |=> (count == $past(count)) && (rem_toggle == $past(rem_toggle)));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (oper && s_q.was_oper && !bit_tick) |=> count == $past(count));
endmodule

// File: rtl/uft_frame_counter.sv
module uft_frame_counter
    import usb_frame_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    output logic [FN_W-1:0] fn,
    output logic            sof,
    output logic            fno
);
    typedef struct packed {
        logic [FN_W-1:0] num;
        logic            sof;
        logic            fno;
    } fc_state_t;

    fc_state_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.sof = advance;
        f_d.fno = 1'b0;
        if (advance) begin
            f_d.num = f_q.num + 1'b1;
            f_d.fno = f_d.num[FN_W-1] ^ f_q.num[FN_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign fn  = f_q.num;
    assign sof = f_q.sof;
    assign fno = f_q.fno;

    p_fn_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> fn == $past(fn) + 1'b1);

    p_fn_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |-> fn == $past(fn));

    p_fno_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fno |-> sof && (fn[FN_W-1] != $past(fn[FN_W-1])));
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import usb_frame_timer_pkg::*;
#(
    parameter logic [CNT_W-1:0]  DEF_INTERVAL = 14'd11999,
    parameter logic [SIZE_W-1:0] DEF_SIZE     = 15'h2778
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [1:0]        func_state,
    input  logic              cfg_wr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_interval,
    output logic [REG_W-1:0]  frame_remaining,
    output logic [FN_W-1:0]   frame_number,
    output logic              sof_pulse,
    output logic [INT_W-1:0]  int_set
);
    localparam int PAD_W = REG_W - 1 - CNT_W;

    logic             oper;
    logic [CNT_W-1:0] interval;
    logic             ivl_toggle;
    logic [CNT_W-1:0] count;
    logic             rem_toggle;
    logic             wrap;
    logic             fno;

    assign oper = (fstate_e'(func_state) == FS_OPER);

    uft_interval_reg #(
        .DEF_INTERVAL (DEF_INTERVAL),
        .DEF_SIZE     (DEF_SIZE)
    ) u_ivl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .wr_data    (cfg_wdata),
        .interval   (interval),
        .ivl_toggle (ivl_toggle),
        .reg_val    (cfg_interval)
    );

    uft_countdown #(
        .DEF_INTERVAL (DEF_INTERVAL)
    ) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .oper       (oper),
        .bit_tick   (bit_tick),
        .interval   (interval),
        .ivl_toggle (ivl_toggle),
        .count      (count),
        .rem_toggle (rem_toggle),
        .wrap       (wrap)
    );

    uft_frame_counter u_fc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (wrap),
        .fn      (frame_number),
        .sof     (sof_pulse),
        .fno     (fno)
    );

    always_comb begin
        int_set          = '0;
        int_set[INT_SOF] = sof_pulse;
        int_set[INT_FNO] = fno;
        if (oper) begin
            frame_remaining = {rem_toggle, {PAD_W{1'b0}}, count};
        end else begin
            frame_remaining = {rem_toggle, {(REG_W-1){1'b0}}};
        end
    end

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> (count == $past(interval)) && (rem_toggle == $past(ivl_toggle)));

    p_sof_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> !sof_pulse || $past(bit_tick, 1));

    p_no_sof_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !oper |=> !sof_pulse);

    p_sof_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(int_set) <= 2 && int_set[INT_FNO] |-> int_set[INT_SOF]);
endmodule

// File: tb/test_usb_frame_timer.sv
module test_usb_frame_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [1:0]  func_state = 2'b00;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_interval;
    logic [31:0] frame_remaining;
    logic [15:0] frame_number;
    logic        sof_pulse;
    logic [7:0]  int_set;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] fn_exp = '0;

    always #2 clk = ~clk;

    usb_frame_timer i_usb_frame_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_tick        (bit_tick),
        .func_state      (func_state),
        .cfg_wr          (cfg_wr),
        .cfg_wdata       (cfg_wdata),
        .cfg_interval    (cfg_interval),
        .frame_remaining (frame_remaining),
        .frame_number    (frame_number),
        .sof_pulse       (sof_pulse),
        .int_set         (int_set)
    );

    // vector: [16] tick, [15] strobe expected, [14] toggle expected, [13:0] count expected
    localparam int NV = 9;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 14'd2},
        {1'b0, 1'b0, 1'b0, 14'd2},
        {1'b1, 1'b0, 1'b0, 14'd1},
        {1'b1, 1'b0, 1'b0, 14'd0},
        {1'b1, 1'b1, 1'b1, 14'd3},
        {1'b1, 1'b0, 1'b1, 14'd2},
        {1'b1, 1'b0, 1'b1, 14'd1},
        {1'b1, 1'b0, 1'b1, 14'd0},
        {1'b1, 1'b1, 1'b1, 14'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic t);
        bit_tick = t;
        @(posedge clk);
        #1;
        bit_tick = 1'b0;
    endtask

    task automatic wr(input logic [31:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 interval reg", cfg_interval, 32'h2778_2EDF);
        chk("R1 frame number", {16'h0, frame_number}, 32'h0);
        chk("R1 strobe/int", {23'h0, sof_pulse, int_set}, 32'h0);
        chk("R1 remaining", frame_remaining, 32'h0);

        // R2 field layout
        wr(32'hFFFF_FFFF);
        chk("R2 all ones", cfg_interval, 32'hFFFF_3FFF);
        chk("R3 toggle not yet loaded", frame_remaining, 32'h0);
        wr(32'h8000_0003);
        chk("R2 interval 3 toggle 1", cfg_interval, 32'h8000_0003);

        // R10 resume is not operational
        func_state = 2'b01;
        step(1);
        step(1);
        chk("R10 resume frozen", frame_remaining, 32'h0);
        chk("R10 no strobe", {31'h0, sof_pulse}, 32'h0);

        // R4 entry loads interval, no strobe
        func_state = 2'b10;
        step(0);
        chk("R4 entry load", frame_remaining, 32'h0000_0003);
        chk("R4 no strobe on entry", {24'h0, int_set}, 32'h0);

        // R5/R6/R7/R8 table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16]);
            if (VEC[i][15]) fn_exp = fn_exp + 1'b1;
            chk("R5 remaining", frame_remaining, {VEC[i][14], 17'h0, VEC[i][13:0]});
            chk("R6 strobe", {31'h0, sof_pulse}, {31'h0, VEC[i][15]});
            chk("R7 int_set", {24'h0, int_set}, {24'h0, 5'h0, VEC[i][15], 2'h0});
            chk("R8 frame number", {16'h0, frame_number}, {16'h0, fn_exp});
        end

        // R3 suspend freezes
        func_state = 2'b11;
        step(1);
        step(1);
        step(1);
        chk("R3 suspend read", frame_remaining, 32'h8000_0000);
        chk("R3 frame number held", {16'h0, frame_number}, {16'h0, fn_exp});

        // R6 toggle reload to 0
        wr(32'h0000_0001);
        func_state = 2'b10;
        step(0);
        chk("R4 re-entry", frame_remaining, 32'h8000_0001);
        step(1);
        chk("R5 count 0", frame_remaining, 32'h8000_0000);
        step(1);
        fn_exp = fn_exp + 1'b1;
        chk("R6 toggle reload", frame_remaining, 32'h0000_0001);
        chk("R6 strobe", {31'h0, sof_pulse}, 32'h1);

        // R9 overflow across both bit-15 flips, interval 0
        wr(32'h0000_0000);
        func_state = 2'b00;
        step(0);
        func_state = 2'b10;
        step(0);
        begin
            int flips = 0;
            int bad_fno = 0;
            int bad_sof = 0;
            logic [15:0] prev;
            for (int k = 0; k < 65540; k++) begin
                prev = fn_exp;
                step(1);
                fn_exp = fn_exp + 1'b1;
                if (sof_pulse !== 1'b1 || frame_number !== fn_exp) bad_sof++;
                if (int_set[5] !== (fn_exp[15] ^ prev[15])) bad_fno++;
                if (fn_exp[15] != prev[15]) flips++;
            end
            chk("R9 overflow mismatches", bad_fno, 0);
            chk("R9 flips seen", flips, 2);
            chk("R8 strobe/number per tick", bad_sof, 0);
        end
        chk("R8 wrapped number", {16'h0, frame_number}, {16'h0, fn_exp});

        finish_run();
    end
endmodule